// File: doc/BRIEF.md
# Dual-Bank Flash Command Interface

This block is a synthesizable model of the control side of a two-bank NOR-style flash device. A host drives it through an asynchronous-style bus. That bus has active-low chip enable, output enable and write enable, an active-low reset/power-down input, a word address and a 16-bit data path. The inputs are sampled on the system clock. Command writes are decoded into three read modes and into the two-write sequences that start a block erase or a word program. A small register array stands in for the storage cells.

An operation timer sets how long an erase or program takes, counted in clock cycles. While it runs, the other bank stays readable. Reads follow the bank address bit without any extra command: an address in the idle bank returns array data, and an address in the busy bank returns the status byte. Pulling the power-down input low aborts any running operation, and the block that was being altered is left reading as invalid until it is erased again.

Top module: `dbflash_ctrl`

## Requirements
- R1: After system reset the block is in array-read mode, the status reads 0x0080 and every word reads 0xFFFF.
- R2: When the power-down input returns high, the block is in array-read mode.
- R3: When the power-down input returns high, the status reads 0x0080 and both error flags are cleared.
- R4: A low power-down input during an erase or program ends the operation at once. After that, every word of the target block reads 0x0000 until the block is erased successfully.
- R5: The data driver enable (`dq_oe`) is high only while the power-down input is high and chip enable and output enable are both low.
- R6: A write window exists while chip enable and write enable are low, output enable is high and power-down is high. The write takes effect when that window closes, using the address and data present in its last sampled cycle. Bus activity with output enable low is not a write.
- R7: Only data bits [7:0] are decoded. 0xFF selects array read, 0x90 selects identifier read and 0x70 selects status read. In identifier read, word offset 0 within a block returns `ID_MFR` and any other offset returns `ID_DEV`. Status read returns {8'h00, status}.
- R8: Status bit 7 is 1 when idle and 0 when busy, bit 5 is the erase error and bit 4 is the program error. All other bits are 0. Command 0x50 clears bits 5 and 4.
- R9: Command 0x40 followed by a data write programs the addressed word to old AND data, taking `PROG_CYC` cycles. Bit 4 is set if the data has a 1 where the old word has a 0. Each of the two writes selects status read.
- R10: Command 0x20 followed by 0xD0 sets every word of the addressed block to 0xFFFF, taking `ERASE_CYC` cycles. Any other confirm value sets bits 5 and 4, erases nothing and selects status read.
- R11: While an operation runs, a read whose top address bit selects the busy bank returns the status, and a read of the other bank returns array data, whatever the read mode.
- R12: Chip enable going inactive does not stop a running operation.
- R13: While an operation runs, commands 0x50, 0x20 and 0x40 are ignored, and 0xFF, 0x90 and 0x70 still change the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low system reset (power-up) |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| pd_n | input | 1 | Active-low reset/power-down |
| addr | input | ADDR_W | Word address; top bit selects the bank, the next BLK_W bits the block |
| dq_i | input | 16 | Data written by the host |
| dq_o | output | 16 | Read data |
| dq_oe | output | 1 | Data driver enable; low means the bus is high-impedance |

## Verification
The bench goes after the background-read rule: with an erase running and the mode set back to array read, it reads both banks. A design that decoded reads by mode alone would return array data from the busy bank. It aborts an erase with the power-down input after loading error flags, then checks that the block reads invalid and that the flags are gone. A design that kept the flags, or left the half-erased data readable, is caught. It issues clear-status during an operation and checks that the flags survive. It programs a word a second time with a value that needs to set a bit, and expects the AND result together with the program error. A design that overwrote the word, or raised no flag, fails that check.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_IDENT  = 2'd1,
        MD_STATUS = 2'd2
    } rdmode_e;

    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_ERASE = 2'd1,
        PEND_PROG  = 2'd2
    } pend_e;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_PROG     = 8'h40;

endpackage

// File: rtl/fcmd_wcap.sv
module fcmd_wcap #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          pd_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          stb,
    output logic [AW-1:0] stb_addr,
    output logic [DW-1:0] stb_data
);
    typedef struct packed {
        logic          act;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } cap_t;

    cap_t cap_d, cap_q;
    logic live;

    assign live = !ce_n && !we_n && oe_n && pd_n;

    always_comb begin
        cap_d     = cap_q;
        cap_d.act = live;
        if (live) begin
            cap_d.a = addr;
            cap_d.d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // window closes on whichever of ce_n / we_n rises first
    assign stb      = cap_q.act && !live && pd_n;
    assign stb_addr = cap_q.a;
    assign stb_data = cap_q.d;
endmodule

// File: rtl/fcmd_wsm.sv
module fcmd_wsm #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (abort) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) tmr_d.busy = 1'b0;
            else                 tmr_d.cnt  = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = len - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0) && !abort;
endmodule

// File: rtl/dbflash_ctrl.sv
module dbflash_ctrl
    import fcmd_pkg::*;
#(
    parameter int          BLK_W     = 1,
    parameter int          WRD_W     = 2,
    parameter int          ERASE_CYC = 40,
    parameter int          PROG_CYC  = 8,
    parameter logic [15:0] ID_MFR    = 16'h00A7,
    parameter logic [15:0] ID_DEV    = 16'h2B5E,
    localparam int         ADDR_W    = 1 + BLK_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_i,
    output logic [15:0]       dq_o,
    output logic              dq_oe
);
    localparam int BKW   = 1 + BLK_W;
    localparam int NBLK  = 2 ** BKW;
    localparam int WPB   = 2 ** WRD_W;
    localparam int NWORD = 2 ** ADDR_W;
    localparam int LONG  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW    = $clog2(LONG + 1);

    typedef struct packed {
        rdmode_e                   mode;
        pend_e                     pend;
        logic                      op_erase;
        logic [ADDR_W-1:0]         tgt;
        logic [15:0]               pdat;
        logic                      es;
        logic                      ps;
        logic [NBLK-1:0]           bad;
        logic [NWORD-1:0][15:0]    mem;
    } st_t;

    localparam st_t RST_ST = '{mode: MD_ARRAY, pend: PEND_NONE, op_erase: 1'b0,
                               tgt: '0, pdat: '0, es: 1'b0, ps: 1'b0,
                               bad: '0, mem: '1};

    st_t st_d, st_q;

    logic              stb;
    logic [ADDR_W-1:0] stb_addr;
    logic [15:0]       stb_data;
    logic              busy, wdone, start;
    logic [CW-1:0]     start_len;
    logic [BKW-1:0]    tgt_blk, rd_blk;
    logic [15:0]       old_w, new_w, rd_word;
    logic [7:0]        stat;
    logic              in_array, busy_bank;

    fcmd_wcap #(.AW(ADDR_W), .DW(16)) u_wcap (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .pd_n(pd_n), .addr(addr), .din(dq_i),
        .stb(stb), .stb_addr(stb_addr), .stb_data(stb_data)
    );

    fcmd_wsm #(.CW(CW)) u_wsm (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(!pd_n),
        .len(start_len), .busy(busy), .done(wdone)
    );

    assign tgt_blk = st_q.tgt[ADDR_W-1:WRD_W];
    assign old_w   = st_q.mem[st_q.tgt];
    assign new_w   = old_w & st_q.pdat;

    always_comb begin
        st_d      = st_q;
        start     = 1'b0;
        start_len = CW'(PROG_CYC);
        if (!pd_n) begin
            st_d.mode = MD_ARRAY;
            st_d.pend = PEND_NONE;
            st_d.es   = 1'b0;
            st_d.ps   = 1'b0;
            if (busy) st_d.bad[tgt_blk] = 1'b1;
        end else begin
            if (wdone) begin
                if (st_q.op_erase) begin
                    for (int w = 0; w < WPB; w++)
                        st_d.mem[{tgt_blk, WRD_W'(w)}] = 16'hFFFF;
                    st_d.bad[tgt_blk] = 1'b0;
                end else begin
                    st_d.mem[st_q.tgt] = new_w;
                    if (new_w != st_q.pdat) st_d.ps = 1'b1;
                end
            end
            if (stb) begin
                if (st_q.pend == PEND_PROG) begin
                    st_d.pend     = PEND_NONE;
                    st_d.mode     = MD_STATUS;
                    st_d.tgt      = stb_addr;
                    st_d.pdat     = stb_data;
                    st_d.op_erase = 1'b0;
                    start         = 1'b1;
                end else if (st_q.pend == PEND_ERASE) begin
                    st_d.pend = PEND_NONE;
                    st_d.mode = MD_STATUS;
                    if (stb_data[7:0] == CMD_CONFIRM) begin
                        st_d.tgt      = stb_addr;
                        st_d.op_erase = 1'b1;
                        start         = 1'b1;
                        start_len     = CW'(ERASE_CYC);
                    end else begin
                        st_d.es = 1'b1;
                        st_d.ps = 1'b1;
                    end
                end else begin
                    case (stb_data[7:0])
                        CMD_RD_ARRAY: st_d.mode = MD_ARRAY;
                        CMD_IDENT:    st_d.mode = MD_IDENT;
                        CMD_RD_STAT:  st_d.mode = MD_STATUS;
                        CMD_CLR_STAT: if (!busy) begin
                            st_d.es = 1'b0;
                            st_d.ps = 1'b0;
                        end
                        CMD_ERASE: if (!busy) begin
                            st_d.pend = PEND_ERASE;
                            st_d.mode = MD_STATUS;
                        end
                        CMD_PROG: if (!busy) begin
                            st_d.pend = PEND_PROG;
                            st_d.mode = MD_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    // read side
    assign rd_blk    = addr[ADDR_W-1:WRD_W];
    assign rd_word   = st_q.bad[rd_blk] ? 16'h0000 : st_q.mem[addr];
    assign stat      = {~busy, 1'b0, st_q.es, st_q.ps, 4'b0000};
    assign in_array  = (st_q.mode == MD_ARRAY);
    assign busy_bank = st_q.tgt[ADDR_W-1];

    always_comb begin
        if (busy && (addr[ADDR_W-1] == busy_bank)) begin
            dq_o = {8'h00, stat};
        end else if (busy) begin
            dq_o = rd_word;
        end else begin
            case (st_q.mode)
                MD_IDENT:  dq_o = (addr[WRD_W-1:0] == '0) ? ID_MFR : ID_DEV;
                MD_STATUS: dq_o = {8'h00, stat};
                default:   dq_o = rd_word;
            endcase
        end
    end

    assign dq_oe = pd_n && !ce_n && !oe_n;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pd_n,
    input logic        rd_bank,
    input logic [15:0] dq_o,
    input logic        dq_oe,
    input logic        busy,
    input logic        wdone,
    input logic        in_array,
    input logic [7:0]  stat,
    input logic        busy_bank
);
    // R2: array-read mode when power-down is released
    assert_array_after_pd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_n) |-> in_array);

    // R3: status cleared to 0x80 when power-down is released
    assert_stat_after_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_n) |-> (stat == 8'h80));

    // R4: power-down ends a running operation
    assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> !busy);

    // R11: busy bank reads return status
    assert_busy_bank_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy && (rd_bank == busy_bank)) |-> (dq_o == {8'h00, stat}));

    // R12: operation keeps running until its count ends, whatever chip enable does
    assert_continue_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pd_n && !wdone) |=> busy);
endmodule

bind dbflash_ctrl fcmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .rd_bank(addr[ADDR_W-1]),
    .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy), .wdone(wdone),
    .in_array(in_array), .stat(stat), .busy_bank(busy_bank)
);

// File: tb/sim_dbflash_ctrl.sv
`timescale 1ns/1ps
module sim_dbflash_ctrl;
    localparam int ERASE_CYC = 40;
    localparam int PROG_CYC  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pd_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dbflash_ctrl #(.BLK_W(1), .WRD_W(2), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
                   .ID_MFR(16'h00A7), .ID_DEV(16'h2B5E)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pd_n(pd_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    // {op(0 write / 1 read), addr, data, expected, requirement number}
    localparam int NV = 21;
    localparam logic [43:0] VEC [NV] = '{
        {4'h0, 4'h0, 16'h0070, 16'h0000, 4'd7},
        {4'h1, 4'h3, 16'h0000, 16'h0080, 4'd1},   // R1 status after reset
        {4'h0, 4'h0, 16'h0090, 16'h0000, 4'd7},
        {4'h1, 4'h0, 16'h0000, 16'h00A7, 4'd7},   // R7 identifier offset 0
        {4'h1, 4'h1, 16'h0000, 16'h2B5E, 4'd7},
        {4'h1, 4'h9, 16'h0000, 16'h2B5E, 4'd7},
        {4'h1, 4'h8, 16'h0000, 16'h00A7, 4'd7},
        {4'h0, 4'h0, 16'h00FF, 16'h0000, 4'd7},
        {4'h1, 4'h5, 16'h0000, 16'hFFFF, 4'd1},   // R1 array erased
        {4'h0, 4'h2, 16'h0020, 16'h0000, 4'd10},
        {4'h0, 4'h2, 16'h0055, 16'h0000, 4'd10},
        {4'h1, 4'h2, 16'h0000, 16'h00B0, 4'd10},  // R10 bad confirm
        {4'h0, 4'h0, 16'h0050, 16'h0000, 4'd8},
        {4'h1, 4'h7, 16'h0000, 16'h0080, 4'd8},   // R8 clear status
        {4'h0, 4'h0, 16'h00FF, 16'h0000, 4'd10},
        {4'h1, 4'h2, 16'h0000, 16'hFFFF, 4'd10},
        {4'h1, 4'h3, 16'h0000, 16'hFFFF, 4'd10},
        {4'h0, 4'h0, 16'hAA70, 16'h0000, 4'd7},
        {4'h1, 4'h0, 16'h0000, 16'h0080, 4'd7},   // R7 high byte ignored
        {4'h0, 4'h0, 16'h00FF, 16'h0000, 4'd7},
        {4'h1, 4'hC, 16'h0000, 16'hFFFF, 4'd7}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d, input logic oe_lvl);
        @(negedge clk);
        addr = a; dq_i = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [3:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check(tag, dq_o, exp);
        #1;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 / R5: bus released after reset, array reads erased
        #1 check("R1 dq_oe idle", {15'b0, dq_oe}, 16'h0000);
        do_read(4'h6, 16'hFFFF, "R1 reset array");

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][43:40] == 4'h0)
                do_write(VEC[i][39:36], VEC[i][35:20], 1'b1);
            else
                do_read(VEC[i][39:36], VEC[i][19:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // R6: output enable low during write window is not a write
        do_write(4'h0, 16'h0090, 1'b0);
        do_read(4'h0, 16'hFFFF, "R6 write with oe low ignored");

        // R9: program, with background read (R11) and chip enable held (R12)
        do_write(4'h1, 16'h0040, 1'b1);
        do_write(4'h1, 16'h1234, 1'b1);
        do_read(4'h1, 16'h0000, "R11 busy bank status");
        do_read(4'h9, 16'hFFFF, "R11 idle bank array");
        @(negedge clk); ce_n = 1'b0; // R12 chip enable toggled while busy
        @(negedge clk); ce_n = 1'b1;
        idle(PROG_CYC);
        do_read(4'h1, 16'h0080, "R12 program finished, ready");
        do_write(4'h0, 16'h00FF, 1'b1);
        do_read(4'h1, 16'h1234, "R9 program result");

        // R9: second program needing a set bit -> AND result plus error
        do_write(4'h1, 16'h0040, 1'b1);
        do_write(4'h1, 16'h00FF, 1'b1);
        idle(PROG_CYC + 2);
        do_read(4'h1, 16'h0090, "R9 program error flag");
        do_write(4'h0, 16'h00FF, 1'b1);
        do_read(4'h1, 16'h0034, "R9 AND result");
        do_write(4'h0, 16'h0050, 1'b1);
        do_write(4'h0, 16'h0070, 1'b1);
        do_read(4'h0, 16'h0080, "R8 cleared");

        // R10 / R11 / R13: erase block 0 with error flags pending
        do_write(4'h4, 16'h0020, 1'b1);
        do_write(4'h4, 16'h0011, 1'b1);
        do_read(4'h4, 16'h00B0, "R10 bad confirm flags");
        do_write(4'h0, 16'h0020, 1'b1);
        do_write(4'h0, 16'h00D0, 1'b1);
        do_read(4'h0, 16'h0030, "R8 busy bit low");
        do_write(4'h0, 16'h00FF, 1'b1);   // R13 mode command accepted
        do_write(4'h0, 16'h0050, 1'b1);   // R13 clear ignored while busy
        do_read(4'h9, 16'hFFFF, "R11 idle bank in array mode");
        do_read(4'h1, 16'h0030, "R11 busy bank overrides array mode");
        idle(ERASE_CYC);
        do_read(4'h1, 16'hFFFF, "R13 array mode kept, R10 erased");
        do_write(4'h0, 16'h0070, 1'b1);
        do_read(4'h0, 16'h00B0, "R13 clear ignored while busy");
        do_write(4'h0, 16'h0050, 1'b1);
        do_read(4'h0, 16'h0080, "R8 clear after idle");

        // R4: abort erase of block 1 through power-down
        do_write(4'h5, 16'h0040, 1'b1);
        do_write(4'h5, 16'h1234, 1'b1);
        idle(PROG_CYC + 2);
        do_write(4'h4, 16'h0020, 1'b1);
        do_write(4'h4, 16'h0000, 1'b1);
        do_write(4'h4, 16'h0020, 1'b1);
        do_write(4'h4, 16'h00D0, 1'b1);
        idle(3);
        @(negedge clk); pd_n = 1'b0;
        @(negedge clk); addr = 4'h5; ce_n = 1'b0; oe_n = 1'b0;
        #1 check("R5 power-down releases bus", {15'b0, dq_oe}, 16'h0000);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; pd_n = 1'b1;
        do_read(4'h5, 16'h0000, "R4 aborted block invalid (R2 array mode)");
        do_read(4'h6, 16'h0000, "R4 aborted block other word");
        do_read(4'h9, 16'hFFFF, "R4 other bank untouched");
        do_write(4'h0, 16'h0070, 1'b1);
        do_read(4'h0, 16'h0080, "R3 status cleared after power-down");

        // R4: erasing the invalid block recovers it
        do_write(4'h4, 16'h0020, 1'b1);
        do_write(4'h4, 16'h00D0, 1'b1);
        idle(ERASE_CYC + 2);
        do_write(4'h0, 16'h00FF, 1'b1);
        do_read(4'h5, 16'hFFFF, "R4 block erased again");

        // R5: output enable high keeps bus released
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        #1 check("R5 oe high releases bus", {15'b0, dq_oe}, 16'h0000);
        @(negedge clk); ce_n = 1'b1;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule